// File: doc/BRIEF.md
# Parallel ATA programmed-I/O strobe sequencer

This block times programmed-I/O transfers on one parallel ATA channel that carries two drives, called device 0 and device 1. It holds a small set of timing registers for each device. A narrow configuration write port loads them. For every accepted access request, the block picks the timing set by the device-select bit and by the access kind: a 16-bit data-port read, a 16-bit data-port write, or an 8-bit task-file access.

Each transfer steps through four states.
- `IDLE` waits for a request. A request seen in `IDLE` is captured and moves the block to `SETUP`; this transition is called *accept*.
- `SETUP` holds the address and chip selects on the bus with no strobe asserted. When its count runs out (*setup_done*) the block moves to `ACTIVE`.
- `ACTIVE` drives the read or write strobe low. When its count runs out (*active_done*) the block moves to `RECOVER`.
- `RECOVER` releases the strobe and pads the rest of the cycle. When its count runs out (*recover_done*) the block returns to `IDLE`, and `done` pulses in that last recovery cycle.

Every phase length is a 4-bit field that stores the number of clocks minus one. The timing byte of an access kind holds the active count in its upper nibble and the recovery count in its lower nibble. A device's setup count is its own nibble in a shared setup word. At accept, the block copies the selected counts, the address and the chip selects into holding registers, so a configuration write made during a transfer does not alter that transfer.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset, `busy` and `done` are low, `ior_n` and `iow_n` are high, and every timing field is 0xF, so the first transfer has 16 setup, 16 active and 16 recovery clocks.
- R2: A transfer runs setup, then active, then recovery. For fields S, A and R, the phases last S+1, A+1 and R+1 clocks.
- R3: The timing byte is chosen from the request. When `req_narrow`=1 the 8-bit byte is used. Otherwise `req_write`=1 uses the write byte and `req_write`=0 uses the read byte. `req_dev` picks which device's bytes are used. In each byte, bits 7:4 hold the active count and bits 3:0 hold the recovery count.
- R4: The `cfg_sel` codes are 0 for setup, 1 for read byte, 2 for write byte and 3 for 8-bit byte. A setup write stores `cfg_data[3:0]` only in the nibble of the device named by `cfg_dev`; device 0 uses bits 3:0 of the setup word and device 1 uses bits 7:4. The other device's setup count is left unchanged.
- R5: Only one strobe is driven per transfer. A read (`req_write`=0) drives `ior_n` low, and a write drives `iow_n` low. The strobe is low only during the active phase, and the other strobe stays high throughout.
- R6: `busy` is high from the clock after accept through the last recovery clock. `done` is high for exactly one clock, which is that last recovery clock.
- R7: A request that arrives while `busy` is high is ignored. No second transfer follows, and the captured address is not replaced.
- R8: `da_o` and `cs_n_o` hold the values captured at accept, unchanged, from the first setup clock to the last recovery clock. `cs_n_o` is the active-low copy of `req_cs`.
- R9: A configuration write made during a transfer changes only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dev | input | 1 | Device whose register is written |
| cfg_sel | input | 2 | Register select: 0 setup, 1 read byte, 2 write byte, 3 8-bit byte |
| cfg_data | input | 8 | Write data (setup uses bits 3:0) |
| req | input | 1 | Access request, taken only when idle |
| req_dev | input | 1 | Target device of the request |
| req_write | input | 1 | 1 write, 0 read |
| req_narrow | input | 1 | 1 for an 8-bit task-file access |
| req_da | input | 3 | Register address for the drive |
| req_cs | input | 2 | Chip selects, active high |
| ior_n | output | 1 | Read strobe, active low |
| iow_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse in the final recovery clock |
| da_o | output | 3 | Held register address |
| cs_n_o | output | 2 | Held chip selects, active low |

## Verification
The assertions assume that `rst_n` is held low for some clocks before the first request. They also assume that the request and configuration inputs are settled at each rising edge. The bench meets both assumptions by changing every input on the falling edge and by releasing reset only after several clocks. The assertions also assume that a request made during a transfer may carry arbitrary fields, since the block must ignore them. The bench deliberately injects such a request, with a different device and address, partway through a transfer.

// File: rtl/ata_pio_pkg.sv
`timescale 1ns/1ps
package ata_pio_pkg;
    localparam int NUM_DEV = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_RECOVER = 2'd3
    } pio_state_e;

    typedef enum logic [1:0] {
        CFG_SETUP  = 2'd0,
        CFG_RD     = 2'd1,
        CFG_WR     = 2'd2,
        CFG_NARROW = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/ata_pio_regs.sv
`timescale 1ns/1ps
// Per-device timing storage and request-side lookup.
module ata_pio_regs
    import ata_pio_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_dev,
    input  cfg_sel_e             cfg_sel,
    input  logic [2*CNT_W-1:0]   cfg_data,
    input  logic                 lk_dev,
    input  logic                 lk_write,
    input  logic                 lk_narrow,
    output logic [CNT_W-1:0]     lk_setup,
    output logic [CNT_W-1:0]     lk_active,
    output logic [CNT_W-1:0]     lk_recov
);
    localparam int BYTE_W = 2 * CNT_W;

    logic [CNT_W-1:0]  su_all [NUM_DEV];
    logic [BYTE_W-1:0] rd_all [NUM_DEV];
    logic [BYTE_W-1:0] wr_all [NUM_DEV];
    logic [BYTE_W-1:0] nr_all [NUM_DEV];
    logic [BYTE_W-1:0] setup_word;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [CNT_W-1:0]  su_q;
        logic [BYTE_W-1:0] rd_q, wr_q, nr_q;
        logic              hit;

        assign hit = cfg_wr && (int'(cfg_dev) == d);

        // R1: slowest timing out of reset; R4: each device owns its setup slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                su_q <= '1;
                rd_q <= '1;
                wr_q <= '1;
                nr_q <= '1;
            end else if (hit) begin
                unique case (cfg_sel)
                    CFG_SETUP:  su_q <= cfg_data[CNT_W-1:0];
                    CFG_RD:     rd_q <= cfg_data;
                    CFG_WR:     wr_q <= cfg_data;
                    CFG_NARROW: nr_q <= cfg_data;
                endcase
            end
        end

        assign su_all[d] = su_q;
        assign rd_all[d] = rd_q;
        assign wr_all[d] = wr_q;
        assign nr_all[d] = nr_q;
        assign setup_word[d*CNT_W +: CNT_W] = su_q;
    end

    logic [BYTE_W-1:0] pick;

    // R3: 8-bit accesses override the read/write choice
    always_comb begin
        if (lk_narrow)     pick = nr_all[lk_dev];
        else if (lk_write) pick = wr_all[lk_dev];
        else               pick = rd_all[lk_dev];
    end

    assign lk_setup  = setup_word[int'(lk_dev)*CNT_W +: CNT_W];
    assign lk_active = pick[BYTE_W-1:CNT_W];
    assign lk_recov  = pick[CNT_W-1:0];
endmodule

// File: rtl/ata_pio_seq.sv
`timescale 1ns/1ps
// Phase sequencer: setup, strobe active, recovery.
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int DA_W  = 3,
    parameter int CS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [DA_W-1:0]   req_da,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [CNT_W-1:0]  tm_setup,
    input  logic [CNT_W-1:0]  tm_active,
    input  logic [CNT_W-1:0]  tm_recov,
    output logic              ior_n,
    output logic              iow_n,
    output logic              busy,
    output logic              done,
    output logic [DA_W-1:0]   da_o,
    output logic [CS_W-1:0]   cs_n_o
);
    pio_state_e       state, nstate;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_q, rec_q;
    logic             wr_q;
    logic [DA_W-1:0]  da_q;
    logic [CS_W-1:0]  cs_q;
    logic             accept, last;

    assign accept = req && (state == ST_IDLE);   // R7: only while idle
    assign last   = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // R2: fixed phase order
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (accept) nstate = ST_SETUP;
            ST_SETUP:   if (last)   nstate = ST_ACTIVE;
            ST_ACTIVE:  if (last)   nstate = ST_RECOVER;
            ST_RECOVER: if (last)   nstate = ST_IDLE;
        endcase
    end

    // Snapshot at accept (R8, R9); counter reloads at each phase change (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            act_q <= '1;
            rec_q <= '1;
            wr_q  <= 1'b0;
            da_q  <= '0;
            cs_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cnt   <= tm_setup;
                        act_q <= tm_active;
                        rec_q <= tm_recov;
                        wr_q  <= req_write;
                        da_q  <= req_da;
                        cs_q  <= req_cs;
                    end
                end
                ST_SETUP:   cnt <= last ? act_q : cnt - 1'b1;
                ST_ACTIVE:  cnt <= last ? rec_q : cnt - 1'b1;
                ST_RECOVER: cnt <= last ? '0    : cnt - 1'b1;
            endcase
        end
    end

    // R5, R6, R8: outputs decoded from the state
    always_comb begin
        ior_n  = 1'b1;
        iow_n  = 1'b1;
        busy   = (state != ST_IDLE);
        done   = (state == ST_RECOVER) && last;
        da_o   = da_q;
        cs_n_o = busy ? ~cs_q : '1;
        if (state == ST_ACTIVE) begin
            if (wr_q) iow_n = 1'b0;
            else      ior_n = 1'b0;
        end
    end
endmodule

// File: rtl/ata_pio_timer.sv
`timescale 1ns/1ps
module ata_pio_timer
    import ata_pio_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int DA_W  = 3,
    parameter int CS_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_dev,
    input  logic [1:0]         cfg_sel,
    input  logic [2*CNT_W-1:0] cfg_data,
    input  logic               req,
    input  logic               req_dev,
    input  logic               req_write,
    input  logic               req_narrow,
    input  logic [DA_W-1:0]    req_da,
    input  logic [CS_W-1:0]    req_cs,
    output logic               ior_n,
    output logic               iow_n,
    output logic               busy,
    output logic               done,
    output logic [DA_W-1:0]    da_o,
    output logic [CS_W-1:0]    cs_n_o
);
    logic [CNT_W-1:0] tm_setup, tm_active, tm_recov;

    ata_pio_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_dev   (cfg_dev),
        .cfg_sel   (cfg_sel_e'(cfg_sel)),
        .cfg_data  (cfg_data),
        .lk_dev    (req_dev),
        .lk_write  (req_write),
        .lk_narrow (req_narrow),
        .lk_setup  (tm_setup),
        .lk_active (tm_active),
        .lk_recov  (tm_recov)
    );

    ata_pio_seq #(.CNT_W(CNT_W), .DA_W(DA_W), .CS_W(CS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .req_da    (req_da),
        .req_cs    (req_cs),
        .tm_setup  (tm_setup),
        .tm_active (tm_active),
        .tm_recov  (tm_recov),
        .ior_n     (ior_n),
        .iow_n     (iow_n),
        .busy      (busy),
        .done      (done),
        .da_o      (da_o),
        .cs_n_o    (cs_n_o)
    );
endmodule

// File: rtl/ata_pio_timer_chk.sv
`timescale 1ns/1ps
module ata_pio_timer_chk #(
    parameter int DA_W = 3,
    parameter int CS_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ior_n,
    input logic            iow_n,
    input logic            busy,
    input logic            done,
    input logic [DA_W-1:0] da_o,
    input logic [CS_W-1:0] cs_n_o
);
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ior_n || iow_n);

    p_strobe_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ior_n || !iow_n) |-> busy);

    p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ior_n && iow_n));

    p_done_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_bus_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(da_o) && $stable(cs_n_o)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ior_n && iow_n && !done));
endmodule

bind ata_pio_timer ata_pio_timer_chk #(.DA_W(DA_W), .CS_W(CS_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ior_n  (ior_n),
    .iow_n  (iow_n),
    .busy   (busy),
    .done   (done),
    .da_o   (da_o),
    .cs_n_o (cs_n_o)
);

// File: tb/sim_ata_pio_timer.sv
`timescale 1ns/1ps
module sim_ata_pio_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_dev = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_data = 8'd0;
    logic       req = 1'b0, req_dev = 1'b0, req_write = 1'b0, req_narrow = 1'b0;
    logic [2:0] req_da = 3'd0;
    logic [1:0] req_cs = 2'd0;
    logic       ior_n, iow_n, busy, done;
    logic [2:0] da_o;
    logic [1:0] cs_n_o;

    int checks = 0;
    int fails  = 0;
    bit over   = 1'b0;

    always #2.5 clk = ~clk;

    ata_pio_timer u0 (.*);

    // {dev, write, narrow, 0, setup[3:0], active[3:0], recov[3:0]}
    localparam logic [15:0] VEC [6] = '{
        16'h0021, 16'h4310, 16'h2500, 16'h8F0F, 16'hC2F3, 16'hE144
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic cfg(input logic dv, input logic [1:0] sel, input logic [7:0] dat);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dev = dv; cfg_sel = sel; cfg_data = dat;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // mode 0 plain, 1 mid-transfer config write, 2 mid-transfer request
    task automatic run_xfer(input logic dv, input logic wr, input logic nar,
                            input logic [2:0] da, input logic [1:0] cs,
                            input int es, input int ea, input int er,
                            input int mode, input logic [1:0] msel,
                            input logic [7:0] mval, input string tag);
        int n, su, ac, rc, dn, dpos, bad_str, bad_bus;
        bit seen;
        n = 0; su = 0; ac = 0; rc = 0; dn = 0; dpos = -1;
        bad_str = 0; bad_bus = 0; seen = 1'b0;
        @(negedge clk);
        req = 1'b1; req_dev = dv; req_write = wr; req_narrow = nar;
        req_da = da; req_cs = cs;
        @(negedge clk);
        req = 1'b0;
        while (busy && n < 200) begin
            if (wr ? !ior_n : !iow_n) bad_str++;
            if (wr ? !iow_n : !ior_n) begin ac++; seen = 1'b1; end
            else if (!seen) su++;
            else rc++;
            if (done) begin dn++; dpos = n; end
            if (da_o != da || cs_n_o != ~cs) bad_bus++;
            n++;
            if (n == 2 && mode == 1) begin
                cfg_wr = 1'b1; cfg_dev = dv; cfg_sel = msel; cfg_data = mval;
            end
            if (n == 2 && mode == 2) begin
                req = 1'b1; req_dev = ~dv; req_write = ~wr; req_narrow = 1'b0;
                req_da = ~da; req_cs = ~cs;
            end
            if (n == 3) begin cfg_wr = 1'b0; req = 1'b0; end
            @(negedge clk);
        end
        chk(su == es, {"R2 setup ", tag}, su, es);
        chk(ac == ea, {"R2 active ", tag}, ac, ea);
        chk(rc == er, {"R2 recovery ", tag}, rc, er);
        chk(dn == 1 && dpos == n - 1, {"R6 done pulse ", tag}, dpos, n - 1);
        chk(bad_str == 0, {"R5 wrong strobe ", tag}, bad_str, 0);
        chk(bad_bus == 0, {"R8 bus held ", tag}, bad_bus, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1 busy/done low", {busy, done}, 0);
        chk(ior_n && iow_n, "R1 strobes high", {ior_n, iow_n}, 3);
        run_xfer(1'b0, 1'b0, 1'b0, 3'd0, 2'b01, 16, 16, 16, 0, 2'd0, 8'd0, "R1 slow default");

        // Table walk: R2, R3, R5
        foreach (VEC[i]) begin
            logic [15:0] v;
            logic [1:0]  sel;
            v = VEC[i];
            sel = v[13] ? 2'd3 : (v[14] ? 2'd2 : 2'd1);
            cfg(v[15], 2'd0, {4'h0, v[11:8]});
            cfg(v[15], sel, v[7:0]);
            run_xfer(v[15], v[14], v[13], 3'(i), 2'b10,
                     int'(v[11:8]) + 1, int'(v[7:4]) + 1, int'(v[3:0]) + 1,
                     0, 2'd0, 8'd0, $sformatf("R3 vec%0d", i));
        end

        // R3: distinct bytes per access kind on device 0
        cfg(1'b0, 2'd0, 8'h00);
        cfg(1'b0, 2'd1, 8'h12);
        cfg(1'b0, 2'd2, 8'h34);
        cfg(1'b0, 2'd3, 8'h56);
        run_xfer(1'b0, 1'b0, 1'b0, 3'd1, 2'b01, 1, 2, 3, 0, 2'd0, 8'd0, "R3 read byte");
        run_xfer(1'b0, 1'b1, 1'b0, 3'd2, 2'b01, 1, 4, 5, 0, 2'd0, 8'd0, "R3 write byte");
        run_xfer(1'b0, 1'b0, 1'b1, 3'd3, 2'b01, 1, 6, 7, 0, 2'd0, 8'd0, "R3 narrow read");
        run_xfer(1'b0, 1'b1, 1'b1, 3'd4, 2'b01, 1, 6, 7, 0, 2'd0, 8'd0, "R3 narrow write");

        // R4: setup slots are independent
        cfg(1'b0, 2'd0, 8'h01);
        cfg(1'b1, 2'd0, 8'h05);
        cfg(1'b1, 2'd1, 8'h00);
        run_xfer(1'b0, 1'b0, 1'b0, 3'd5, 2'b01, 2, 2, 3, 0, 2'd0, 8'd0, "R4 dev0 setup kept");
        run_xfer(1'b1, 1'b0, 1'b0, 3'd6, 2'b10, 6, 1, 1, 0, 2'd0, 8'd0, "R4 dev1 setup");
        cfg(1'b1, 2'd0, 8'hFA);
        run_xfer(1'b0, 1'b0, 1'b0, 3'd5, 2'b01, 2, 2, 3, 0, 2'd0, 8'd0, "R4 dev0 after dev1 write");

        // R9: config write during a transfer
        cfg(1'b0, 2'd0, 8'h00);
        cfg(1'b0, 2'd1, 8'h33);
        run_xfer(1'b0, 1'b0, 1'b0, 3'd2, 2'b01, 1, 4, 4, 1, 2'd1, 8'h11, "R9 old timing");
        run_xfer(1'b0, 1'b0, 1'b0, 3'd2, 2'b01, 1, 2, 2, 0, 2'd0, 8'd0, "R9 new timing");

        // R7: request during a transfer is ignored
        run_xfer(1'b0, 1'b0, 1'b0, 3'd3, 2'b01, 1, 2, 2, 2, 2'd0, 8'd0, "R7 busy request");
        for (int k = 0; k < 3; k++) begin
            chk(!busy && ior_n && iow_n, "R7 no second transfer", busy, 0);
            @(negedge clk);
        end
        chk(da_o == 3'd3, "R7 address kept", da_o, 3);

        over = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule